// File: doc/BRIEF.md
# Memory Lock Protection Unit

This unit keeps the lock byte that guards an on-chip program memory and its data memory, and it rules on every access request presented to it. The lock byte can be narrowed by a program command, which can only move bits from unprogrammed (1) to programmed (0). Only a chip-erase command returns the byte to all ones.

Each clock the unit samples one request and, on the following cycle, raises either an allow flag or a deny flag. A request is one of five kinds:

- an external memory write;
- an external verification read;
- an external fuse write;
- a self-programming write;
- a program-memory read.

The last two carry the section the code runs from and the section being targeted, where 0 is the application section and 1 is the boot section. The external parallel and serial modes are governed by the same rules, so the mode is not an input.

A combinational interrupt-block flag tells the core to hold off interrupts in one case: code is running in the application section while the vectors sit in the boot section and application reads by boot code are locked.

Top module: `mem_lock_guard`

## Requirements
- R1: While reset is low and after it, until a command arrives, `lock_q` reads 8'hFF, and `grant` and `deny` are 0.
- R2: A program command sets bits 5:0 of the lock byte to the old value ANDed with `cmd_data[5:0]` on the next clock. Bits 7:6 always read 1.
- R3: A chip erase sets the lock byte to 8'hFF on the next clock. When a program command arrives in the same cycle, the erase wins.
- R4: A request with `req_valid` high is judged against the lock byte held before that edge. In the next cycle exactly one of `grant` or `deny` is 1 for one cycle. With no request, both are 0. Kind codes 5, 6 and 7 are always denied.
- R5: Kind 0 (external write) and kind 2 (fuse write) are allowed only when lock bits 1:0 are 2'b11.
- R6: Kind 1 (verification read) is denied when lock bit 1 is 0. This covers bits 1:0 equal to 00, and the undefined 01 which is treated like 00.
- R7: Kind 3 (self-programming write) is denied when bit 2 is 0 if it targets the application section (`req_tgt`=0). It is denied when bit 4 is 0 if it targets the boot section (`req_tgt`=1).
- R8: Kind 4 (program read) is always allowed when `req_src` equals `req_tgt`. A read by boot code of the application section is denied when bit 3 is 0. A read by application code of the boot section is denied when bit 5 is 0.
- R9: `int_block` equals `vec_in_boot` AND NOT `run_in_boot` AND NOT lock bit 3, with no clock delay.
- R10: An allowed or denied request never changes the lock byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_prog | input | 1 | Lock-byte program strobe |
| cmd_data | input | 8 | Value ANDed into the lock byte |
| cmd_erase | input | 1 | Chip-erase strobe |
| req_valid | input | 1 | Access request present |
| req_kind | input | 3 | Request kind code (0 to 4 defined) |
| req_src | input | 1 | Section the requesting code runs from (1 = boot) |
| req_tgt | input | 1 | Section targeted (1 = boot) |
| run_in_boot | input | 1 | Core currently executes from the boot section |
| vec_in_boot | input | 1 | Interrupt vectors placed in the boot section |
| lock_q | output | 8 | Current lock byte |
| grant | output | 1 | Request allowed (one cycle after the request) |
| deny | output | 1 | Request denied (one cycle after the request) |
| int_block | output | 1 | Interrupts must be held off |

## Verification
The block has no parameters, so the bench builds it as it stands, and its six meaningful lock bits give only 64 states. The bench reaches every one of them by erase and program, and at each state it applies all eight kind codes with all four source and target pairings. It also applies all four interrupt-input combinations. This brings the undefined lock encodings and every cross-section read rule within reach, together with the erase-over-program collision and the AND-only update.

// File: rtl/mem_lock_guard.sv
module mem_lock_guard (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_prog,
  input  logic [7:0] cmd_data,
  input  logic       cmd_erase,
  input  logic       req_valid,
  input  logic [2:0] req_kind,
  input  logic       req_src,
  input  logic       req_tgt,
  input  logic       run_in_boot,
  input  logic       vec_in_boot,
  output logic [7:0] lock_q,
  output logic       grant,
  output logic       deny,
  output logic       int_block
);

  logic [7:0] lock_r;
  logic       allow;

  wire ext_open   = (lock_r[1:0] == 2'b11);
  wire vrfy_open  = lock_r[1];
  wire spw_app_ok = lock_r[2];
  wire rd_app_ok  = lock_r[3];
  wire spw_bt_ok  = lock_r[4];
  wire rd_bt_ok   = lock_r[5];

  always_comb begin
    case (req_kind)
      3'd0, 3'd2: allow = ext_open;
      3'd1:       allow = vrfy_open;
      3'd3:       allow = req_tgt ? spw_bt_ok : spw_app_ok;
      3'd4: begin
        if (req_src == req_tgt) allow = 1'b1;
        else if (req_src)       allow = rd_app_ok;
        else                    allow = rd_bt_ok;
      end
      default:    allow = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_r <= 8'hFF;
      grant  <= 1'b0;
      deny   <= 1'b0;
    end else begin
      if (cmd_erase)     lock_r <= 8'hFF;
      else if (cmd_prog) lock_r <= {2'b11, lock_r[5:0] & cmd_data[5:0]};
      grant <= req_valid & allow;
      deny  <= req_valid & ~allow;
    end
  end

  assign lock_q    = lock_r;
  assign int_block = vec_in_boot & ~run_in_boot & ~lock_r[3];

  assert_clear_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_erase |=> ((lock_q & ~$past(lock_q)) == 8'h00));

  assert_erase_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_erase |=> (lock_q == 8'hFF));

  assert_one_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (grant ^ deny));

  assert_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!grant && !deny));

  assert_ext_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_kind == 3'd0 || req_kind == 3'd2) && lock_q[1:0] != 2'b11) |=> deny);

  assert_high_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q[7:6] == 2'b11);

  assert_req_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_erase && !cmd_prog) |=> $stable(lock_q));

endmodule

// File: tb/test_mem_lock_guard.sv
`timescale 1ns/1ps
module test_mem_lock_guard;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_prog = 1'b0, cmd_erase = 1'b0, req_valid = 1'b0;
  logic [7:0] cmd_data = 8'h00;
  logic [2:0] req_kind = 3'd0;
  logic       req_src = 1'b0, req_tgt = 1'b0, run_in_boot = 1'b0, vec_in_boot = 1'b0;
  logic [7:0] lock_q;
  logic       grant, deny, int_block;
  int n_vec = 0, n_bad = 0;

  always #2 clk = ~clk;

  mem_lock_guard i_mem_lock_guard (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_allow(logic [7:0] L, int k, logic s, logic t);
    case (k)
      0, 2: return L[1] & L[0];
      1:    return L[1];
      3:    return t ? L[4] : L[2];
      4:    return (s == t) ? 1'b1 : (s ? L[3] : L[5]);
      default: return 1'b0;
    endcase
  endfunction

  task automatic cycle();
    @(posedge clk); #1;
  endtask

  task automatic command(logic er, logic pr, logic [7:0] d);
    @(negedge clk);
    cmd_erase = er; cmd_prog = pr; cmd_data = d;
    cycle();
    cmd_erase = 0; cmd_prog = 0;
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #5;
    check("R1", {lock_q, grant, deny}, {8'hFF, 2'b00});
    @(negedge clk); rst_n = 1;
    cycle();
    check("R1", {lock_q, grant, deny}, {8'hFF, 2'b00});

    for (int v = 0; v < 64; v++) begin
      logic [7:0] L;
      command(1, 0, 8'h00);
      check("R3", lock_q, 8'hFF);
      command(0, 1, {2'b00, v[5:0]});
      L = {2'b11, v[5:0]};
      check("R2", lock_q, L);
      for (int k = 0; k < 8; k++)
        for (int st = 0; st < 4; st++) begin
          logic e;
          @(negedge clk);
          req_valid = 1; req_kind = k[2:0]; req_src = st[1]; req_tgt = st[0];
          e = exp_allow(L, k, st[1], st[0]);
          cycle();
          req_valid = 0;
          if (k < 3)       check("R5/R6", {grant, deny}, {e, ~e});
          else if (k == 3) check("R7", {grant, deny}, {e, ~e});
          else if (k == 4) check("R8", {grant, deny}, {e, ~e});
          else             check("R4", {grant, deny}, 2'b01);
          check("R10", lock_q, L);
        end
      cycle();
      check("R4", {grant, deny}, 2'b00);
      for (int c = 0; c < 4; c++) begin
        run_in_boot = c[1]; vec_in_boot = c[0]; #0.5;
        check("R9", int_block, c[0] & ~c[1] & ~L[3]);
      end
      command(0, 1, 8'h35 ^ {2'b00, v[5:0]});
      check("R2", lock_q, {2'b11, L[5:0] & (6'h35 ^ v[5:0])});
    end

    command(0, 1, 8'h0F);
    @(negedge clk); cmd_erase = 1; cmd_prog = 1; cmd_data = 8'h00;
    cycle();
    cmd_erase = 0; cmd_prog = 0;
    check("R3", lock_q, 8'hFF);
    command(0, 1, 8'hFF);
    check("R2", lock_q, 8'hFF);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule